// File: doc/BRIEF.md
# Millisecond Real-Time Counter with Coherent Seconds Snapshot

This block keeps elapsed time as two registers: a seconds count and a millisecond count inside the current second. A reference tick input is divided by a parameter to give a 1 kHz advance. Software reads the time over a simple 32-bit register bus with an address, read and write strobes, and registered read data.

Reading the milliseconds register also copies the live seconds count into a separate snapshot register in the same clock edge. Software therefore reads milliseconds first and then the snapshot. It forms `seconds*1000 + milliseconds` as a 32-bit 1 kHz value. This pair never tears, even when a second boundary falls between the two reads. A write to the seconds register sets the time. A suspend indication is accepted but never stops counting.

Top module: `msec_rtc`

## Requirements
- R1: After reset, reads of the seconds register (offset 0x08), snapshot register (0x0C) and milliseconds register (0x10) all return zero.
- R2: Milliseconds advance by exactly one for every REF_DIV cycles in which `ref_tick` is high. Cycles with `ref_tick` low do not count.
- R3: Milliseconds count 0 to 999. The advance after 999 gives 0 and increments seconds, and seconds wrap from 0xFFFFFFFF to 0.
- R4: Read data appears on `bus_rdata` in the cycle after the cycle in which `bus_rd` is high, and is zero in every cycle after a cycle without a read. A read of 0x10 returns milliseconds in bits 9:0 with the upper bits zero.
- R5: A read of 0x10 copies the seconds value held before that edge into the snapshot register. A read of 0x0C returns the snapshot, and no other access changes it. An advance in the same cycle as the read does not reach the snapshot.
- R6: A read of 0x08 returns the live seconds count.
- R7: A write to 0x08 loads `bus_wdata` into seconds and clears milliseconds and the prescaler. A write in the same cycle as a reference tick takes precedence over that tick.
- R8: Writes to any offset other than 0x08 change no register.
- R9: The `suspend` input has no effect on counting.
- R10: A read of any offset other than 0x08, 0x0C or 0x10 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_tick | input | 1 | Reference tick enable, one count per cycle high |
| suspend | input | 1 | Low-power indication, does not gate counting |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |

## Verification
Every result is one register stage away from its stimulus. A read strobe and a tick driven in one cycle both take effect at the next rising edge. From then on `bus_rdata` holds the value that existed before that edge. The bench therefore drives each cycle's inputs at a falling edge and advances its own model past the rising edge. It compares `bus_rdata` at the following falling edge, every cycle, including the zero after idle cycles. The internal reset synchroniser adds two cycles after `rst_n` rises, and the bench keeps all strobes and ticks idle through that window.

// File: rtl/msrtc_pkg.sv
package msrtc_pkg;
  localparam logic [7:0] OFF_SEC    = 8'h08;
  localparam logic [7:0] OFF_SNAP   = 8'h0C;
  localparam logic [7:0] OFF_MSEC   = 8'h10;
  localparam int         MS_PER_SEC = 1000;
  localparam int         MS_W       = $clog2(MS_PER_SEC);
endpackage

// File: rtl/msrtc_prescale.sv
module msrtc_prescale #(
  parameter int DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic clr,
  output logic ms_tick
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    cnt_d   = cnt_q;
    ms_tick = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (ref_tick) begin
      if (at_last) begin
        cnt_d   = '0;
        ms_tick = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: without a reference tick or a clear, the prescaler holds its count
  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_tick && !clr) |=> $stable(cnt_q));
  // R7: a clear leaves the prescaler at zero
  a_r7_clear_prescaler: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/msrtc_count.sv
module msrtc_count
  import msrtc_pkg::*;
#(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ms_tick,
  input  logic             load,
  input  logic [SEC_W-1:0] load_val,
  output logic [MS_W-1:0]  msec,
  output logic [SEC_W-1:0] sec
);
  localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_SEC - 1);

  logic [MS_W-1:0]  ms_q, ms_d;
  logic [SEC_W-1:0] sec_q, sec_d;

  always_comb begin
    ms_d  = ms_q;
    sec_d = sec_q;
    if (load) begin
      ms_d  = '0;
      sec_d = load_val;
    end else if (ms_tick) begin
      if (ms_q == MS_LAST) begin
        ms_d  = '0;
        sec_d = sec_q + 1'b1;
      end else begin
        ms_d = ms_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_q  <= '0;
      sec_q <= '0;
    end else begin
      ms_q  <= ms_d;
      sec_q <= sec_d;
    end
  end

  assign msec = ms_q;
  assign sec  = sec_q;

  // R3: milliseconds never leave the 0..999 range
  a_r3_ms_range: assert property (@(posedge clk) disable iff (!rst_n)
    ms_q <= MS_LAST);
  // R3: the advance after 999 rolls into the next second
  a_r3_rollover: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_tick && !load && ms_q == MS_LAST) |=> (ms_q == '0 && sec_q == $past(sec_q) + 1'b1));
  // R7: a load sets seconds and clears milliseconds
  a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sec_q == $past(load_val) && ms_q == '0));
endmodule

// File: rtl/msrtc_regs.sv
module msrtc_regs
  import msrtc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SEC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [MS_W-1:0]   msec,
  input  logic [SEC_W-1:0]  sec,
  output logic              load,
  output logic [DATA_W-1:0] rdata
);
  logic              hit_sec, hit_snap, hit_ms, snap_en;
  logic [SEC_W-1:0]  snap_q, snap_d;
  logic [DATA_W-1:0] rdata_d;

  assign hit_sec  = (addr == ADDR_W'(OFF_SEC));
  assign hit_snap = (addr == ADDR_W'(OFF_SNAP));
  assign hit_ms   = (addr == ADDR_W'(OFF_MSEC));
  assign load     = wr && hit_sec;
  assign snap_en  = rd && hit_ms;

  always_comb begin
    snap_d = snap_q;
    if (snap_en) snap_d = sec;
  end

  always_comb begin
    rdata_d = '0;
    if (rd) begin
      if (hit_sec)       rdata_d = DATA_W'(sec);
      else if (hit_snap) rdata_d = DATA_W'(snap_q);
      else if (hit_ms)   rdata_d = DATA_W'(msec);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      rdata  <= '0;
    end else begin
      snap_q <= snap_d;
      rdata  <= rdata_d;
    end
  end

  // R5: the snapshot captures the seconds seen at the millisecond read
  a_r5_snap_capture: assert property (@(posedge clk) disable iff (!rst_n)
    snap_en |=> (snap_q == $past(sec)));
  // R5: no other access disturbs the snapshot
  a_r5_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_en |=> $stable(snap_q));
  // R4: read data is zero after a cycle without a read
  a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> (rdata == '0));
endmodule

// File: rtl/msec_rtc.sv
module msec_rtc
  import msrtc_pkg::*;
#(
  parameter int REF_DIV = 1000,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              suspend,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int SEC_W = DATA_W;

  logic             rst_meta, rst_s;
  logic             ms_tick, load;
  logic [MS_W-1:0]  ms_val;
  logic [SEC_W-1:0] sec_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  msrtc_prescale #(.DIV(REF_DIV)) u_presc (
    .clk(clk), .rst_n(rst_s), .ref_tick(ref_tick), .clr(load), .ms_tick(ms_tick)
  );

  msrtc_count #(.SEC_W(SEC_W)) u_count (
    .clk(clk), .rst_n(rst_s), .ms_tick(ms_tick), .load(load),
    .load_val(bus_wdata), .msec(ms_val), .sec(sec_val)
  );

  msrtc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEC_W(SEC_W)) u_regs (
    .clk(clk), .rst_n(rst_s), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .msec(ms_val), .sec(sec_val), .load(load), .rdata(bus_rdata)
  );

  // R9: a millisecond advance still lands while suspend is high
  a_r9_suspend_counts: assert property (@(posedge clk) disable iff (!rst_s)
    (suspend && ms_tick && !load && ms_val != MS_W'(MS_PER_SEC - 1))
      |=> (ms_val == $past(ms_val) + 1'b1));
endmodule

// File: tb/tb_msec_rtc.sv
module tb_msec_rtc;
  localparam int DIV = 3;

  logic        clk = 1'b0;
  logic        rst_n, ref_tick, suspend, bus_rd, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int          m_pre = 0;
  int          m_ms  = 0;
  logic [31:0] m_sec = '0;
  logic [31:0] m_snap = '0;

  always #2.5 clk = ~clk;

  msec_rtc #(.REF_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .suspend(suspend),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [31:0] expect_read(logic rd, logic [7:0] a);
    if (!rd) return 32'd0;
    case (a)
      8'h08:   return m_sec;
      8'h0C:   return m_snap;
      8'h10:   return 32'(m_ms);
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(logic rd, logic wr, logic [7:0] a, logic [31:0] wd,
                      logic tk, logic sp, string tag);
    logic [31:0] exp;
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    ref_tick = tk; suspend = sp;
    exp = expect_read(rd, a);
    if (rd && a == 8'h10) m_snap = m_sec;
    if (wr && a == 8'h08) begin
      m_sec = wd; m_ms = 0; m_pre = 0;
    end else if (tk) begin
      if (m_pre == DIV - 1) begin
        m_pre = 0;
        if (m_ms == 999) begin
          m_ms = 0; m_sec = m_sec + 32'd1;
        end else m_ms++;
      end else m_pre++;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, bus_rdata, exp);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; ref_tick = 1'b0; suspend = 1'b0;
    bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset values
    step(1, 0, 8'h08, 0, 0, 0, "R1 seconds");
    step(1, 0, 8'h0C, 0, 0, 0, "R1 snapshot");
    step(1, 0, 8'h10, 0, 0, 0, "R1 msec");

    // R2: advance counts ticks, not cycles
    for (int i = 0; i < 2 * DIV - 1; i++) begin
      step(0, 0, 0, 0, 1, 0, "R4 idle");
      step(0, 0, 0, 0, 0, 0, "R4 idle");
    end
    step(1, 0, 8'h10, 0, 0, 0, "R2 one ms after partial ticks");
    step(0, 0, 0, 0, 1, 0, "R4 idle");
    step(1, 0, 8'h10, 0, 0, 0, "R2 second ms");

    // R7: write beats a same-cycle tick
    step(0, 1, 8'h08, 32'h0001_2345, 1, 0, "R7 load");
    step(1, 0, 8'h10, 0, 0, 0, "R7 msec cleared");
    step(1, 0, 8'h08, 0, 0, 0, "R7 seconds loaded");

    // R8: writes elsewhere ignored
    step(0, 1, 8'h0C, 32'hDEAD_BEEF, 0, 0, "R8 write snapshot");
    step(0, 1, 8'h10, 32'h0000_0155, 0, 0, "R8 write msec");
    step(1, 0, 8'h08, 0, 0, 0, "R8 seconds kept");
    step(1, 0, 8'h0C, 0, 0, 0, "R8 snapshot kept");
    step(1, 0, 8'h10, 0, 0, 0, "R8 msec kept");

    // R10: unmapped reads
    step(1, 0, 8'h04, 0, 0, 0, "R10 read 0x04");
    step(1, 0, 8'h14, 0, 0, 0, "R10 read 0x14");

    // R3 / R5 / R9: tear-free snapshot across a seconds wrap, suspend high
    step(0, 1, 8'h08, 32'hFFFF_FFFF, 0, 0, "R7 load near wrap");
    for (int i = 0; i < 5000 && !(m_ms == 999 && m_pre == DIV - 1); i++)
      step(0, 0, 0, 0, 1, 1, "R9 idle under suspend");
    step(1, 0, 8'h10, 0, 1, 1, "R5 msec at boundary");
    step(1, 0, 8'h0C, 0, 0, 0, "R5 snapshot pre-wrap");
    step(1, 0, 8'h08, 0, 0, 0, "R3 seconds wrapped");
    step(1, 0, 8'h10, 0, 0, 0, "R3 msec wrapped");
    step(1, 0, 8'h10, 0, 0, 0, "R5 refresh msec");
    step(1, 0, 8'h0C, 0, 0, 0, "R5 snapshot refreshed");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      logic rd, wr;
      case ($urandom % 5)
        0: a = 8'h08;
        1: a = 8'h0C;
        2: a = 8'h10;
        3: a = 8'h04;
        default: a = 8'h14;
      endcase
      rd = ($urandom % 2) == 0;
      wr = !rd && (($urandom % 40) == 0);
      step(rd, wr, a, $urandom, ($urandom % 4) != 0, $urandom % 2,
           (a == 8'h08) ? "R6 random" : (a == 8'h0C) ? "R5 random" :
           (a == 8'h10) ? "R4 random" : "R10 random");
    end

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule